// File: doc/BRIEF.md
# Multiply-Accumulate Unit with Sticky Status Flags

This block multiplies two operands and adds the product to a running sum. The sum is held as a 32-bit accumulator with an 8-bit extension byte above it, so the full running value is 40 bits wide. A configuration input selects signed or unsigned arithmetic for each operation. A one-cycle start pulse launches the operation. The product is formed in one cycle and added in the next, and a busy indication covers both cycles.

Every operation updates a set of sticky status flags:

- zero result
- hard overflow, meaning a wrap of the extension byte
- soft overflow, meaning the result has left the 32-bit range
- sign change against a programmed expected sign
- operation-done, used in processor-driven mode
- a summary interrupt flag, which drives the interrupt line

Software clears flags one at a time by writing ones on a clear port. A separate strobe zeroes the running value and also drops the flags that describe it.

Top module: `mac_unit`

## Requirements
- R1: Each accepted operation adds the 32-bit product of `op_a` and `op_b` to the 40-bit value {`ovf`,`acc`}, modulo 2^40. When `signed_en` is 1 at start, both operands and the product are taken as two's complement and the product is sign-extended. When it is 0, they are taken as unsigned and the product is zero-extended. The value changes on no other occasion.
- R2: A start pulse sampled while idle is accepted. `status[0]` (busy) is 1 for exactly the two cycles after that edge. The result is visible after the third rising edge, counting the accepting edge as the first. A start pulse sampled while busy is ignored.
- R3: In signed mode, `status[3]` (hard overflow) sets when an operation moves `ovf` from 0x7F to 0x80, or from 0x80 to 0x7F.
- R4: In unsigned mode, `status[3]` sets when an operation moves `ovf` from 0xFF to 0x00.
- R5: `status[1]` (soft overflow) sets when the 40-bit result lies outside the range of a 32-bit value of the active signedness.
- R6: `status[2]` (zero) sets when an operation leaves the whole 40-bit value equal to zero.
- R7: `status[5]` (sign change) sets only in signed mode, when bit 39 of the result differs from `exp_sign`.
- R8: `status[4]` (done) sets on completion of an operation only while `mcu_mode` is 1.
- R9: `status[6]` (interrupt) sets in any cycle in which hard overflow is set, or soft overflow and `soft_ie` are both set, or done and `mcu_mode` are both set. `irq` equals `status[6]`.
- R10: Flags in `status[6:1]` are sticky. Each flag clears when a 1 is written on the matching bit of `flag_clr`. A flag event in the same cycle wins over that write. Writes to bits 7 and 0 have no effect, and `status[7]` always reads 0.
- R11: A `clr_acc` pulse zeroes `acc` and `ovf`. It also clears the sign-change, hard-overflow and zero flags, and leaves the other flags unchanged.
- R12: If `clr_acc` falls on the cycle in which an operation would write, the clear wins. The value becomes zero and that operation sets no flag.
- R13: After reset, `acc`, `ovf`, `status` and `irq` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_a | input | 16 | First multiplier operand |
| op_b | input | 16 | Second multiplier operand |
| start | input | 1 | Start strobe, one cycle |
| signed_en | input | 1 | 1 selects two's-complement arithmetic, sampled at start |
| exp_sign | input | 1 | Expected sign of the result for the sign-change check |
| soft_ie | input | 1 | Lets soft overflow raise the interrupt flag |
| mcu_mode | input | 1 | Enables the done flag |
| clr_acc | input | 1 | Zeroes the running value and its descriptive flags |
| flag_clr | input | 8 | Write-one-to-clear mask for the status flags |
| acc | output | 32 | Low 32 bits of the running value |
| ovf | output | 8 | Extension byte, bits 39..32 of the running value |
| status | output | 8 | Flags: 6 interrupt, 5 sign change, 4 done, 3 hard overflow, 2 zero, 1 soft overflow, 0 busy |
| irq | output | 1 | Interrupt line |

## Verification
The bench drives the extension byte through its exact wrap points. In unsigned mode it runs 257 full-scale additions to pass 0xFF to 0x00. In signed mode it runs 512 additions of 2^30 to reach 0x7F to 0x80, then one negative product to return to 0x7F. A design that tests the wrong byte, or flags any carry into the extension, would raise hard overflow on an earlier step or miss the crossing.

It also checks the following:
- A start pulse held into the busy window, which a faulty design would add twice.
- A clear arriving on the write cycle, which a faulty design would let through as a stale result or flag.
- Clearing the interrupt flag while hard overflow is still set, where a faulty design would drop the level-driven interrupt.

// File: rtl/mac_pkg.sv
package mac_pkg;
   localparam int ST_BUSY = 0;
   localparam int ST_SOVF = 1;
   localparam int ST_ZERO = 2;
   localparam int ST_HOVF = 3;
   localparam int ST_RDY  = 4;
   localparam int ST_SCHG = 5;
   localparam int ST_INT  = 6;
   localparam int ST_W    = 8;

   typedef struct packed {
      logic hovf;
      logic sovf;
      logic zero;
      logic schg;
   } mac_evt_t;
endpackage

// File: rtl/mac_mult.sv
module mac_mult #(
   parameter int OP_W  = 16,
   parameter int TOT_W = 40
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             sgn_in,
   input  logic [OP_W-1:0]  a,
   input  logic [OP_W-1:0]  b,
   output logic             busy,
   output logic             prod_vld,
   output logic             sgn_out,
   output logic [TOT_W-1:0] prod
);
   localparam int PW = 2 * OP_W;

   logic             s1_q, s2_q, sgn_q;
   logic [OP_W-1:0]  a_q, b_q;
   logic [PW-1:0]    ax, bx, p_w;
   logic [TOT_W-1:0] prod_q;
   logic             take;

   assign busy = s1_q | s2_q;
   assign take = start & ~busy;

   // widen each operand to the product width; low PW bits are exact either way
   assign ax  = {{OP_W{sgn_q & a_q[OP_W-1]}}, a_q};
   assign bx  = {{OP_W{sgn_q & b_q[OP_W-1]}}, b_q};
   assign p_w = ax * bx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_q   <= 1'b0;
         s2_q   <= 1'b0;
         sgn_q  <= 1'b0;
         a_q    <= '0;
         b_q    <= '0;
         prod_q <= '0;
      end else begin
         s1_q <= take;
         s2_q <= s1_q;
         if (take) begin
            a_q   <= a;
            b_q   <= b;
            sgn_q <= sgn_in;
         end
         if (s1_q)
            prod_q <= {{(TOT_W-PW){sgn_q & p_w[PW-1]}}, p_w};
      end
   end

   assign prod_vld = s2_q;
   assign sgn_out  = sgn_q;
   assign prod     = prod_q;
endmodule

// File: rtl/mac_accum.sv
module mac_accum
   import mac_pkg::*;
#(
   parameter int ACC_W = 32,
   parameter int EXT_W = 8,
   localparam int TOT_W = ACC_W + EXT_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             vld,
   input  logic             clr,
   input  logic             sgn,
   input  logic             exp_sign,
   input  logic [TOT_W-1:0] prod,
   output logic [TOT_W-1:0] val,
   output logic             done,
   output mac_evt_t         evt
);
   localparam logic [EXT_W-1:0] EXT_SMAX = {1'b0, {(EXT_W-1){1'b1}}};
   localparam logic [EXT_W-1:0] EXT_SMIN = {1'b1, {(EXT_W-1){1'b0}}};
   localparam logic [EXT_W-1:0] EXT_UMAX = '1;
   localparam logic [EXT_W-1:0] EXT_ZERO = '0;

   logic [TOT_W-1:0] val_q, sum;
   logic [EXT_W-1:0] old_ext, new_ext;
   logic [EXT_W:0]   top_s;

   assign sum     = val_q + prod;
   assign old_ext = val_q[TOT_W-1:ACC_W];
   assign new_ext = sum[TOT_W-1:ACC_W];
   assign top_s   = sum[TOT_W-1:ACC_W-1];
   assign done    = vld & ~clr;

   always_comb begin
      if (sgn) begin
         evt.hovf = ((old_ext == EXT_SMAX) && (new_ext == EXT_SMIN)) ||
                    ((old_ext == EXT_SMIN) && (new_ext == EXT_SMAX));
         evt.sovf = (top_s != '0) && (top_s != '1);
      end else begin
         evt.hovf = (old_ext == EXT_UMAX) && (new_ext == EXT_ZERO);
         evt.sovf = (new_ext != EXT_ZERO);
      end
      evt.zero = (sum == '0);
      evt.schg = sgn & (sum[TOT_W-1] ^ exp_sign);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     val_q <= '0;
      else if (clr)   val_q <= '0;
      else if (vld)   val_q <= sum;
   end

   assign val = val_q;
endmodule

// File: rtl/mac_status.sv
module mac_status
   import mac_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            done,
   input  mac_evt_t        evt,
   input  logic            clr,
   input  logic            busy,
   input  logic            mcu_mode,
   input  logic            soft_ie,
   input  logic [ST_W-1:0] w1c,
   output logic [ST_W-1:0] status
);
   logic [ST_W-1:0] flg, set_v, auto_v, base;
   logic            int_nxt, int_q;
   logic            unused_w1c;

   assign unused_w1c = ^{w1c[ST_W-1], w1c[ST_BUSY]};

   always_comb begin
      set_v          = '0;
      set_v[ST_SOVF] = done & evt.sovf;
      set_v[ST_ZERO] = done & evt.zero;
      set_v[ST_HOVF] = done & evt.hovf;
      set_v[ST_RDY]  = done & mcu_mode;
      set_v[ST_SCHG] = done & evt.schg;
      auto_v          = '0;
      auto_v[ST_ZERO] = clr;
      auto_v[ST_HOVF] = clr;
      auto_v[ST_SCHG] = clr;
   end

   assign base = (flg & ~w1c & ~auto_v) | set_v;

   for (genvar i = ST_SOVF; i <= ST_SCHG; i++) begin : g_flag
      logic bit_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) bit_q <= 1'b0;
         else        bit_q <= base[i];
      end
      assign flg[i] = bit_q;
   end
   assign flg[ST_BUSY] = 1'b0;
   assign flg[ST_INT]  = int_q;
   assign flg[ST_W-1]  = 1'b0;

   assign int_nxt = (int_q & ~w1c[ST_INT]) | base[ST_HOVF] |
                    (base[ST_SOVF] & soft_ie) | (base[ST_RDY] & mcu_mode);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) int_q <= 1'b0;
      else        int_q <= int_nxt;
   end

   always_comb begin
      status          = flg;
      status[ST_BUSY] = busy;
   end
endmodule

// File: rtl/mac_unit.sv
module mac_unit
   import mac_pkg::*;
#(
   parameter int OP_W  = 16,
   parameter int ACC_W = 32,
   parameter int EXT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [OP_W-1:0]  op_a,
   input  logic [OP_W-1:0]  op_b,
   input  logic             start,
   input  logic             signed_en,
   input  logic             exp_sign,
   input  logic             soft_ie,
   input  logic             mcu_mode,
   input  logic             clr_acc,
   input  logic [7:0]       flag_clr,
   output logic [ACC_W-1:0] acc,
   output logic [EXT_W-1:0] ovf,
   output logic [7:0]       status,
   output logic             irq
);
   localparam int TOT_W = ACC_W + EXT_W;

   if (ACC_W < 2 * OP_W) begin : g_bad_acc
      $error("mac_unit: ACC_W must hold a full product");
   end
   if (EXT_W < 2) begin : g_bad_ext
      $error("mac_unit: EXT_W must be at least 2");
   end

   logic             busy, prod_vld, sgn, done;
   logic [TOT_W-1:0] prod, val;
   mac_evt_t         evt;

   mac_mult #(.OP_W(OP_W), .TOT_W(TOT_W)) u_mult (
      .clk(clk), .rst_n(rst_n), .start(start), .sgn_in(signed_en),
      .a(op_a), .b(op_b), .busy(busy), .prod_vld(prod_vld),
      .sgn_out(sgn), .prod(prod)
   );

   mac_accum #(.ACC_W(ACC_W), .EXT_W(EXT_W)) u_accum (
      .clk(clk), .rst_n(rst_n), .vld(prod_vld), .clr(clr_acc), .sgn(sgn),
      .exp_sign(exp_sign), .prod(prod), .val(val), .done(done), .evt(evt)
   );

   mac_status u_status (
      .clk(clk), .rst_n(rst_n), .done(done), .evt(evt), .clr(clr_acc),
      .busy(busy), .mcu_mode(mcu_mode), .soft_ie(soft_ie),
      .w1c(flag_clr), .status(status)
   );

   assign acc = val[ACC_W-1:0];
   assign ovf = val[TOT_W-1:ACC_W];
   assign irq = status[ST_INT];
endmodule

// File: rtl/mac_unit_chk.sv
module mac_unit_chk #(
   parameter int ACC_W = 32,
   parameter int EXT_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic             clr_acc,
   input logic             mcu_mode,
   input logic [7:0]       flag_clr,
   input logic [ACC_W-1:0] acc,
   input logic [EXT_W-1:0] ovf,
   input logic [7:0]       status,
   input logic             irq
);
   AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status[0]) |=> status[0]);                                   // R2
   AST_BUSY_END: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status[0]) |-> ##2 !status[0]);                              // R2
   AST_BUSY_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status[0]) |-> $past(start));                                // R2
   AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!status[0] && !clr_acc) |=> $stable({ovf, acc}));                 // R1
   AST_RDY_MODE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status[4]) |-> $past(mcu_mode));                             // R8
   AST_IRQ_HOVF: assert property (@(posedge clk) disable iff (!rst_n)
      status[3] |-> irq);                                                // R9
   AST_ZERO_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (status[2] && !clr_acc && !flag_clr[2]) |=> status[2]);            // R10
   AST_CLR_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
      clr_acc |=> (acc == '0 && ovf == '0 && !status[3] && !status[2] && !status[5])); // R11
endmodule

bind mac_unit mac_unit_chk #(.ACC_W(ACC_W), .EXT_W(EXT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .clr_acc(clr_acc),
   .mcu_mode(mcu_mode), .flag_clr(flag_clr), .acc(acc), .ovf(ovf),
   .status(status), .irq(irq)
);

// File: tb/mac_unit_test.sv
`timescale 1ns/1ps
module mac_unit_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] op_a = '0, op_b = '0;
   logic        start = 1'b0, signed_en = 1'b0, exp_sign = 1'b0;
   logic        soft_ie = 1'b0, mcu_mode = 1'b0, clr_acc = 1'b0;
   logic [7:0]  flag_clr = '0;
   logic [31:0] acc;
   logic [7:0]  ovf, status;
   logic        irq;

   int total = 0, bad = 0;
   logic [39:0] m_val = '0;
   logic [7:0]  m_st  = '0;
   bit          finished = 0;

   always #4 clk = ~clk;

   mac_unit uut (
      .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .start(start),
      .signed_en(signed_en), .exp_sign(exp_sign), .soft_ie(soft_ie),
      .mcu_mode(mcu_mode), .clr_acc(clr_acc), .flag_clr(flag_clr),
      .acc(acc), .ovf(ovf), .status(status), .irq(irq)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic chk_all(input string tag);
      chk({tag, " value"}, {24'h0, ovf, acc}, {24'h0, m_val});
      chk({tag, " status"}, {56'h0, status}, {56'h0, m_st});
      chk({tag, " irq"}, {63'h0, irq}, {63'h0, m_st[6]});
   endtask

   task automatic upd_int();
      if (m_st[3] || (m_st[1] && soft_ie) || (m_st[4] && mcu_mode)) m_st[6] = 1'b1;
   endtask

   task automatic model_op(input logic [15:0] a, input logic [15:0] b);
      logic [39:0] pe, s;
      longint      v;
      logic [7:0]  o, n;
      if (signed_en) pe = 40'(longint'($signed(a)) * longint'($signed(b)));
      else           pe = 40'(longint'(a) * longint'(b));
      s = m_val + pe;
      o = m_val[39:32];
      n = s[39:32];
      v = {{24{s[39]}}, s};
      if (signed_en) begin
         if ((o == 8'h7F && n == 8'h80) || (o == 8'h80 && n == 8'h7F)) m_st[3] = 1'b1;
         if (v > 64'sd2147483647 || v < -64'sd2147483648) m_st[1] = 1'b1;
         if (s[39] != exp_sign) m_st[5] = 1'b1;
      end else begin
         if (o == 8'hFF && n == 8'h00) m_st[3] = 1'b1;
         if (s > 40'hFFFF_FFFF) m_st[1] = 1'b1;
      end
      if (s == '0) m_st[2] = 1'b1;
      if (mcu_mode) m_st[4] = 1'b1;
      m_val = s;
      upd_int();
   endtask

   task automatic do_op(input logic [15:0] a, input logic [15:0] b);
      @(negedge clk); op_a = a; op_b = b; start = 1'b1;
      @(negedge clk); start = 1'b0;
      @(negedge clk);
      @(negedge clk);
      model_op(a, b);
   endtask

   task automatic w1c(input logic [7:0] m);
      @(negedge clk); flag_clr = m;
      @(negedge clk); flag_clr = '0;
      m_st = m_st & ~(m & 8'h7E);
      upd_int();
   endtask

   task automatic clear_acc();
      @(negedge clk); clr_acc = 1'b1;
      @(negedge clk); clr_acc = 1'b0;
      m_val = '0;
      m_st[5] = 1'b0; m_st[3] = 1'b0; m_st[2] = 1'b0;
      upd_int();
   endtask

   task automatic setup(input bit sg, input bit es, input bit ie, input bit mm);
      @(negedge clk); signed_en = sg; exp_sign = es; soft_ie = ie; mcu_mode = mm;
      clear_acc();
      w1c(8'hFF);
   endtask

   task automatic t_reset();
      chk("R13 reset value", {24'h0, ovf, acc}, 64'h0);
      chk("R13 reset status", {56'h0, status}, 64'h0);
      chk("R13 reset irq", {63'h0, irq}, 64'h0);
   endtask

   task automatic t_unsigned_mcu();
      setup(0, 0, 0, 1);
      do_op(16'd3, 16'd4);
      chk_all("R1 R8 R9 unsigned 3*4");
      chk("R8 done flag", {63'h0, status[4]}, 64'h1);
      do_op(16'hFFFF, 16'd2);
      chk_all("R1 unsigned ffff*2");
      w1c(8'h81);
      chk_all("R10 bits 7 and 0 ignored");
      w1c(8'h50);
      chk_all("R10 clear done and interrupt");
      chk("R10 status after clear", {56'h0, status}, 64'h0);
   endtask

   task automatic t_busy();
      setup(0, 0, 0, 0);
      @(negedge clk); op_a = 16'd3; op_b = 16'd5; start = 1'b1;
      @(negedge clk); op_a = 16'd100; op_b = 16'd100;
      chk("R2 busy after accept", {63'h0, status[0]}, 64'h1);
      @(negedge clk); start = 1'b0;
      chk("R2 busy second cycle", {63'h0, status[0]}, 64'h1);
      chk("R2 no early result", {24'h0, ovf, acc}, 64'h0);
      @(negedge clk);
      chk("R2 idle after write", {63'h0, status[0]}, 64'h0);
      model_op(16'd3, 16'd5);
      chk_all("R2 start while busy ignored");
      @(negedge clk);
      chk("R2 no second operation", {24'h0, ovf, acc}, 64'd15);
   endtask

   task automatic t_signed_zero();
      setup(1, 0, 0, 0);
      do_op(16'hFFFB, 16'd3);
      chk_all("R1 R7 signed -5*3");
      chk("R7 sign change set", {63'h0, status[5]}, 64'h1);
      do_op(16'd5, 16'd3);
      chk_all("R6 zero result");
      chk("R6 zero flag", {63'h0, status[2]}, 64'h1);
      clear_acc();
      chk_all("R11 clear drops flags");
   endtask

   task automatic t_soft();
      setup(0, 0, 0, 0);
      do_op(16'hFFFF, 16'hFFFF);
      do_op(16'hFFFF, 16'hFFFF);
      chk_all("R5 unsigned soft overflow");
      chk("R9 no irq without enable", {63'h0, irq}, 64'h0);
      setup(0, 0, 1, 0);
      do_op(16'hFFFF, 16'hFFFF);
      do_op(16'hFFFF, 16'hFFFF);
      chk_all("R5 R9 soft overflow with enable");
      chk("R9 irq with enable", {63'h0, irq}, 64'h1);
   endtask

   task automatic t_unsigned_hard();
      setup(0, 0, 0, 0);
      for (int i = 0; i < 257; i++) begin
         do_op(16'hFFFF, 16'hFFFF);
         chk_all("R4 unsigned step");
      end
      chk("R4 hard overflow set", {63'h0, status[3]}, 64'h1);
      w1c(8'h40);
      chk("R9 irq held by hard overflow", {63'h0, irq}, 64'h1);
   endtask

   task automatic t_signed_hard();
      setup(1, 0, 0, 0);
      for (int i = 0; i < 512; i++) begin
         do_op(16'h8000, 16'h8000);
         chk_all("R3 signed step");
      end
      chk("R3 reach 0x80", {56'h0, ovf}, 64'h80);
      chk("R3 hard overflow up", {63'h0, status[3]}, 64'h1);
      chk("R7 sign change at wrap", {63'h0, status[5]}, 64'h1);
      w1c(8'h48);
      chk_all("R10 R9 clear hard overflow and irq");
      do_op(16'h8000, 16'h7FFF);
      chk_all("R3 signed 0x80 to 0x7F");
      chk("R3 hard overflow down", {63'h0, status[3]}, 64'h1);
   endtask

   task automatic t_clear_wins();
      setup(0, 0, 0, 1);
      do_op(16'd7, 16'd9);
      w1c(8'hFF);
      @(negedge clk); op_a = 16'd0; op_b = 16'd0; start = 1'b1;
      @(negedge clk); start = 1'b0;
      @(negedge clk); clr_acc = 1'b1;
      @(negedge clk); clr_acc = 1'b0;
      m_val = '0;
      chk_all("R12 clear wins over write");
      chk("R12 no zero or done flag", {56'h0, status}, 64'h0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_unsigned_mcu();
      t_busy();
      t_signed_zero();
      t_soft();
      t_unsigned_hard();
      t_signed_hard();
      t_clear_wins();
      if (!finished) begin
         finished = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      #(8 * 200000);
      if (!finished) begin
         finished = 1;
         total++;
         bad++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule